// File: doc/BRIEF.md
# Bias-Offset Split-Polarity FIR Filter

This block is a fixed-coefficient FIR filter. Its accumulation logic never carries a sign. Each incoming two's complement sample gets a constant offset of half the input range, which makes it an unsigned number. The offset samples move along a delay line. Every coefficient is broken into canonical signed digits at elaboration. The shifted copies of a sample that go with plus digits are summed in one unsigned adder network. Those that go with minus digits are summed in a second unsigned adder network. Neither network has a select line or any runtime control.

The last stage subtracts the minus-digit total from the plus-digit total. It also adds a constant, fixed at elaboration, that cancels the offset. The result is equal, bit for bit, to a plain signed FIR over the same coefficients.

An option rewrites a coefficient's digit string so the two networks carry a similar number of terms. A +1, 0, -1 run from the most significant digit downward becomes 0, +1, +1. The rewrite leaves the coefficient value and the count of nonzero digits unchanged. The filter runs as a stream: one sample goes in when the input strobe is high, and one result comes out a fixed number of cycles later.

Top module: `fir_sign_split`

## Requirements
- R1: Synchronous active-high reset clears `out_vld` and `y_out` to zero, and loads every delay stage with the offset value, which stands for a sample of zero.
- R2: For each accepted sample n, `y_out` equals the sum over taps k of coef[k]·x[n−k] in two's complement. Samples before the first one count as zero. Coefficient k sits at bits [k·CW +: CW] of `COEFS`, and tap 0 is the newest sample.
- R3: `out_vld` is high for exactly one cycle for each cycle in which `in_vld` was high, three clock edges later, and never otherwise.
- R4: While `in_vld` is low the delay line holds its contents. In every cycle where `out_vld` is low, `y_out` keeps its last value.
- R5: Results stay exact at the input extremes −2^(DW−1) and 2^(DW−1)−1, including long runs of either value and runs that alternate between them.
- R6: The digit-balancing option (`BALANCE` = 1 or 0) changes how terms are split between the two networks and leaves every result unchanged.
- R7: The plus-digit and minus-digit totals never exceed (2^DW−1) times the summed weight of their own digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample strobe |
| x_in | input | DW | Signed input sample |
| out_vld | output | 1 | Result strobe, three edges after the sample |
| y_out | output | OW | Signed filter result, OW = DW+CW+clog2(NTAPS)+2 |

## Verification
The range and hold properties assume that `rst` is held for at least one edge before any sample, and that `in_vld` is never unknown. The bench keeps both inputs at defined values from time zero and releases reset only after three edges. It then drives every input code once, an impulse, and runs of alternating extremes with irregular gaps. All of these stay inside the two's complement range, and the unsigned totals were sized for that range.

// File: rtl/fir_sgn_pkg.sv
package fir_sgn_pkg;

  // Widest digit string the elaboration helpers handle
  localparam int MAXD = 34;

  typedef struct packed {
    logic [MAXD-1:0] neg;
    logic [MAXD-1:0] pos;
  } digit_split_t;

  // Canonical signed-digit recoding, with optional plus/minus rebalancing
  function automatic digit_split_t csd_split(input longint c, input bit balance);
    digit_split_t d;
    longint x;
    int np;
    int nn;
    d = '0;
    x = c;
    for (int i = 0; i < MAXD; i++) begin
      if (x[0]) begin
        if (x[1]) begin
          d.neg[i] = 1'b1;
          x = x + 1;
        end else begin
          d.pos[i] = 1'b1;
          x = x - 1;
        end
      end
      x = x >>> 1;
    end
    if (balance) begin
      for (int j = 0; j < MAXD-2; j++) begin
        np = $countones(d.pos);
        nn = $countones(d.neg);
        if (nn > np + 1 && d.neg[j] && !d.pos[j+1] && !d.neg[j+1] && d.pos[j+2]) begin
          // +4 -1 == +2 +1
          d.neg[j] = 1'b0; d.pos[j+2] = 1'b0; d.pos[j+1] = 1'b1; d.pos[j] = 1'b1;
        end else if (np > nn + 1 && d.pos[j] && !d.pos[j+1] && !d.neg[j+1] && d.neg[j+2]) begin
          // -4 +1 == -2 -1
          d.pos[j] = 1'b0; d.neg[j+2] = 1'b0; d.neg[j+1] = 1'b1; d.neg[j] = 1'b1;
        end
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/sgn_tapline.sv
module sgn_tapline #(
  parameter int DW    = 8,
  parameter int NTAPS = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [DW-1:0]         x_in,
  output logic [NTAPS*DW-1:0]   taps,
  output logic                  taps_vld
);

  localparam logic [DW-1:0] BIAS = DW'(1) << (DW-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) taps[k*DW +: DW] <= BIAS;
      taps_vld <= 1'b0;
    end else begin
      taps_vld <= in_vld;
      if (in_vld) begin
        // adding half range to a two's complement word flips its MSB
        taps[0 +: DW] <= x_in ^ BIAS;
        for (int k = 1; k < NTAPS; k++) taps[k*DW +: DW] <= taps[(k-1)*DW +: DW];
      end
    end
  end

  // R4
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(taps));

endmodule

// File: rtl/sgn_digit_sum.sv
module sgn_digit_sum #(
  parameter int                    DW    = 8,
  parameter int                    NTAPS = 5,
  parameter int                    DGW   = 9,
  parameter int                    OW    = 21,
  parameter logic [NTAPS*DGW-1:0]  MASK  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [NTAPS*DW-1:0]  taps,
  output logic [OW-1:0]        sum
);

  logic [OW-1:0] acc;

  // Unsigned shift-add over this polarity's digits only; no selects at runtime
  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      for (int j = 0; j < DGW; j++) begin
        if (MASK[k*DGW + j]) acc = acc + (OW'(taps[k*DW +: DW]) << j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sum <= '0;
    else if (en) sum <= acc;
  end

endmodule

// File: rtl/sgn_merge.sv
module sgn_merge #(
  parameter int             OW      = 21,
  parameter longint         POS_MAX = 0,
  parameter longint         NEG_MAX = 0,
  parameter logic [OW-1:0]  COMP    = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [OW-1:0]         pos_sum,
  input  logic [OW-1:0]         neg_sum,
  output logic                  out_vld,
  output logic signed [OW-1:0]  y_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      y_out   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) y_out <= $signed(pos_sum - neg_sum + COMP);
    end
  end

  // R7
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> longint'(pos_sum) <= POS_MAX);

  // R7
  neg_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> longint'(neg_sum) <= NEG_MAX);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(y_out));

endmodule

// File: rtl/fir_sign_split.sv
module fir_sign_split #(
  parameter int                   DW      = 8,
  parameter int                   CW      = 8,
  parameter int                   NTAPS   = 5,
  parameter logic [NTAPS*CW-1:0]  COEFS   = 40'h1D_80_7F_97_03,
  parameter bit                   BALANCE = 1'b1,
  localparam int                  OW      = DW + CW + $clog2(NTAPS) + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic signed [DW-1:0]  x_in,
  output logic                  out_vld,
  output logic signed [OW-1:0]  y_out
);

  localparam int DGW = CW + 1;

  function automatic logic [NTAPS*DGW-1:0] build_mask(input bit want_pos);
    logic [NTAPS*DGW-1:0] m;
    fir_sgn_pkg::digit_split_t s;
    m = '0;
    for (int k = 0; k < NTAPS; k++) begin
      s = fir_sgn_pkg::csd_split(longint'($signed(COEFS[k*CW +: CW])), BALANCE);
      m[k*DGW +: DGW] = want_pos ? s.pos[DGW-1:0] : s.neg[DGW-1:0];
    end
    return m;
  endfunction

  function automatic longint mask_weight(input logic [NTAPS*DGW-1:0] m);
    longint w;
    w = 0;
    for (int k = 0; k < NTAPS; k++)
      for (int j = 0; j < DGW; j++)
        if (m[k*DGW + j]) w = w + (longint'(1) << j);
    return w;
  endfunction

  localparam logic [NTAPS*DGW-1:0] POS_M   = build_mask(1'b1);
  localparam logic [NTAPS*DGW-1:0] NEG_M   = build_mask(1'b0);
  localparam longint               UMAX    = (longint'(1) << DW) - 1;
  localparam longint               POS_MAX = UMAX * mask_weight(POS_M);
  localparam longint               NEG_MAX = UMAX * mask_weight(NEG_M);
  localparam longint               CSUM    = mask_weight(POS_M) - mask_weight(NEG_M);
  localparam longint               COMP_L  = -((longint'(1) << (DW-1)) * CSUM);
  localparam logic [OW-1:0]        COMP_V  = OW'(COMP_L);

  logic [NTAPS*DW-1:0] taps;
  logic                t_vld;
  logic                s_vld;
  logic [OW-1:0]       pos_sum;
  logic [OW-1:0]       neg_sum;

  sgn_tapline #(.DW(DW), .NTAPS(NTAPS)) u_taps (
    .clk(clk), .rst(rst), .in_vld(in_vld), .x_in(x_in),
    .taps(taps), .taps_vld(t_vld)
  );

  sgn_digit_sum #(.DW(DW), .NTAPS(NTAPS), .DGW(DGW), .OW(OW), .MASK(POS_M)) u_pos (
    .clk(clk), .rst(rst), .en(t_vld), .taps(taps), .sum(pos_sum)
  );

  sgn_digit_sum #(.DW(DW), .NTAPS(NTAPS), .DGW(DGW), .OW(OW), .MASK(NEG_M)) u_neg (
    .clk(clk), .rst(rst), .en(t_vld), .taps(taps), .sum(neg_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) s_vld <= 1'b0;
    else     s_vld <= t_vld;
  end

  sgn_merge #(.OW(OW), .POS_MAX(POS_MAX), .NEG_MAX(NEG_MAX), .COMP(COMP_V)) u_merge (
    .clk(clk), .rst(rst), .in_vld(s_vld), .pos_sum(pos_sum), .neg_sum(neg_sum),
    .out_vld(out_vld), .y_out(y_out)
  );

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld, 3));

endmodule

// File: tb/sim_fir_sign_split.sv
module sim_fir_sign_split;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int OW = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] x_in = '0;
  logic out_vld, out_vld1;
  logic signed [OW-1:0] y0, y1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int hist [5];
  int coef [5] = '{3, -105, 127, -128, 29};
  int exp_q [$];
  int cyc_q [$];
  bit have_last = 1'b0;
  int last_y = 0;
  bit running = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fir_sign_split #(.BALANCE(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .x_in(x_in), .out_vld(out_vld), .y_out(y0)
  );

  fir_sign_split #(.BALANCE(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .x_in(x_in), .out_vld(out_vld1), .y_out(y1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send(input int v);
    int e;
    @(negedge clk);
    for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    e = 0;
    for (int k = 0; k < 5; k++) e += coef[k] * hist[k];
    exp_q.push_back(e);
    cyc_q.push_back(cyc);
    in_vld = 1'b1;
    x_in = DW'(v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (running) begin
      chk(out_vld == out_vld1, "R6 strobe", int'(out_vld1), int'(out_vld));
      if (out_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected strobe", 1, 0);
        end else begin
          int e;
          int c;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          chk(int'(y0) == e, "R2/R5 result", int'(y0), e);
          chk(int'(y1) == e, "R6 unbalanced result", int'(y1), e);
          chk(cyc - c == 3, "R3 latency", cyc - c, 3);
          last_y = int'(y0);
          have_last = 1'b1;
        end
      end else if (have_last) begin
        chk(int'(y0) == last_y, "R4 hold", int'(y0), last_y);
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL R3: watchdog expired, got %0d pending expected 0", exp_q.size());
    finish_run();
  end

  initial begin
    for (int k = 0; k < 5; k++) hist[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
    chk(y0 == '0, "R1 y_out", int'(y0), 0);
    running = 1'b1;

    // R1/R2: first results see zero history; R5: every code incl. extremes
    for (int v = -128; v < 128; v++) send(v);
    idle(6);

    // R2: impulse response
    send(1);
    for (int i = 0; i < 5; i++) send(0);
    idle(4);

    // R5: long runs of each extreme
    for (int i = 0; i < 8; i++) send(-128);
    for (int i = 0; i < 8; i++) send(127);

    // R4/R5: alternating extremes with irregular gaps
    for (int i = 0; i < 40; i++) begin
      send((i % 2) ? 127 : -128);
      idle(i % 3);
    end

    // R2: mixed pattern with gaps
    for (int i = 0; i < 60; i++) begin
      send(((i * 37) % 256) - 128);
      if (i % 5 == 0) idle(2);
    end

    idle(8);
    // R3: every sample produced exactly one result
    chk(exp_q.size() == 0, "R3 outstanding", exp_q.size(), 0);
    finish_run();
  end

endmodule